// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block arbitrates interrupts for a small 8-bit processor core. It keeps one 8-bit control and flag register that the processor can write and read at any time. Three request sources feed the register: a falling edge on an active-low external pin, a one-cycle timer overflow pulse and a one-cycle converter-done pulse. Each source has its own enable bit and its own pending flag. A master enable bit gates all three.

Arbitration runs only in cycles where the processor's phase tick is high. At that tick the block looks for pending, enabled sources. It acts only if the master enable is set, the call stack has room and no register write is in progress. It then grants the source with the highest priority and raises a one-cycle call request that carries a fixed vector for that source. In the same step it clears the granted flag and the master enable.

A return-from-interrupt strobe sets the master enable again, and a plain return strobe does not touch it. Software may set the master enable inside a handler to allow nesting.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x00 and callReq is 0. Bit 7 always reads 0.
- R2: A write with regWrEn loads the register, with bit 7 forced to 0. The bit layout is: bit0 master enable, bit1 external enable, bit2 timer enable, bit3 converter enable, bit4 external flag, bit5 timer flag, bit6 converter flag.
- R3: A high-to-low transition of extPinN sets bit4 at the next clock edge. A pin that stays low or rises sets nothing.
- R4: A timerOvf pulse sets bit5 and an adcDone pulse sets bit6. Each flag is recorded whatever the enable bits hold.
- R5: A grant raises callReq for exactly one cycle, in the cycle after the tick. callVector is 0x04 for external, 0x08 for timer and 0x0C for converter.
- R6: When several pending sources are enabled, external wins over timer, and timer wins over converter.
- R7: A grant clears the granted source's flag and the master enable.
- R8: While stackFull is 1, no grant is made and the flags stay set. The pending request is granted at a later tick once stackFull is 0.
- R9: retiStrobe sets the master enable. retStrobe leaves it unchanged.
- R10: Arbitration happens only in cycles with phaseTick high. A request raised between two ticks is granted at the later tick.
- R11: A register write has priority over a hardware flag set in the same cycle. No grant is made in a write cycle. A flag stays set until it is granted or written to 0.
- R12: No grant is made while the master enable is 0 or while the only pending source is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| phaseTick | input | 1 | Instruction-phase tick that enables arbitration |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register contents |
| extPinN | input | 1 | External request pin, falling-edge sensitive |
| timerOvf | input | 1 | Timer overflow pulse |
| adcDone | input | 1 | Converter end-of-conversion pulse |
| stackFull | input | 1 | Call stack has no free entry |
| retiStrobe | input | 1 | Return-from-interrupt executed |
| retStrobe | input | 1 | Plain return executed |
| callReq | output | 1 | One-cycle call request |
| callVector | output | 8 | Vector address for the call |

## Verification
Every register effect (an edge on the pin, an event pulse, a write, a return strobe, or a grant clearing bits) shows on regRdData one clock edge after the cycle that causes it. The grant made at a tick edge shows on callReq and callVector in the cycle right after that edge, for that cycle only. The bench drives inputs and samples outputs on the falling clock edge. A tick driven for one cycle is therefore checked at the very next falling edge, and the cycles between ticks are sampled one by one to show that no call appears.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC  = 3;
  localparam int REG_W    = 8;
  localparam int MEN_BIT  = 0;
  localparam int EN_LSB   = 1;
  localparam int FLAG_LSB = EN_LSB + NUM_SRC;
  localparam int RSV_BIT  = FLAG_LSB + NUM_SRC;

  typedef struct packed {
    logic               take;
    logic [NUM_SRC-1:0] grant;
  } ctrl_strobe_t;
endpackage

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  input  logic             extPinN,
  input  logic             timerOvf,
  input  logic             adcDone,
  input  logic             retiStrobe,
  input  ctrl_strobe_t     strb,
  output logic [REG_W-1:0] ctrlReg
);
  logic               extPrev;
  logic [NUM_SRC-1:0] srcEvt;
  logic [REG_W-1:0]   nextReg;

  assign srcEvt = {adcDone, timerOvf, extPrev & ~extPinN};

  always_comb begin
    nextReg = ctrlReg;
    if (strb.take)      nextReg[MEN_BIT] = 1'b0;
    else if (retiStrobe) nextReg[MEN_BIT] = 1'b1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (strb.grant[i]) nextReg[FLAG_LSB+i] = 1'b0;
      if (srcEvt[i])     nextReg[FLAG_LSB+i] = 1'b1;
    end
    if (regWrEn) nextReg = regWrData;
    nextReg[RSV_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      extPrev <= 1'b1;
    end else begin
      ctrlReg <= nextReg;
      extPrev <= extPinN;
    end
  end
endmodule

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseTick,
  input  logic             stackFull,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] ctrlReg,
  output ctrl_strobe_t     strb,
  output logic             callReq,
  output logic [VEC_W-1:0] callVector
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] winner;
  logic [IDX_W-1:0]   winIdx;
  logic               found;

  assign pending = ctrlReg[FLAG_LSB +: NUM_SRC] & ctrlReg[EN_LSB +: NUM_SRC];

  always_comb begin
    winner = '0;
    winIdx = '0;
    found  = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && !found) begin
        winner[i] = 1'b1;
        winIdx    = IDX_W'(i);
        found     = 1'b1;
      end
    end
  end

  assign strb.take  = phaseTick & ctrlReg[MEN_BIT] & ~stackFull & ~regWrEn & found;
  assign strb.grant = strb.take ? winner : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      callReq    <= 1'b0;
      callVector <= '0;
    end else begin
      callReq <= strb.take;
      if (strb.take)
        callVector <= VEC_W'(VEC_BASE + int'(winIdx) * VEC_STEP);
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irq_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             phaseTick,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             extPinN,
  input  logic             timerOvf,
  input  logic             adcDone,
  input  logic             stackFull,
  input  logic             retiStrobe,
  input  logic             retStrobe,
  output logic             callReq,
  output logic [VEC_W-1:0] callVector
);
  ctrl_strobe_t   strb;
  logic [REG_W-1:0] ctrlReg;
  logic             unusedRet;

  assign unusedRet = retStrobe;   // plain return has no effect on this block
  assign regRdData = ctrlReg;

  irq_datapath u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .extPinN(extPinN), .timerOvf(timerOvf), .adcDone(adcDone),
    .retiStrobe(retiStrobe), .strb(strb), .ctrlReg(ctrlReg)
  );

  irq_control #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_ctl (
    .clk(clk), .rstN(rstN), .phaseTick(phaseTick), .stackFull(stackFull),
    .regWrEn(regWrEn), .ctrlReg(ctrlReg), .strb(strb),
    .callReq(callReq), .callVector(callVector)
  );
endmodule

// File: rtl/prio_irq_ctrl_checker.sv
module prio_irq_ctrl_checker #(parameter int VEC_W = 8) (
  input logic             clk,
  input logic             rstN,
  input logic             phaseTick,
  input logic             regWrEn,
  input logic [7:0]       regRdData,
  input logic             stackFull,
  input logic             retiStrobe,
  input logic             callReq,
  input logic [VEC_W-1:0] callVector
);
  p_rsv_zero_r1: assert property (@(posedge clk) disable iff (!rstN) regRdData[7] == 1'b0);

  p_vec_legal_r5: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> (callVector == 8'h04 || callVector == 8'h08 || callVector == 8'h0C));

  p_pulse_r5: assert property (@(posedge clk) disable iff (!rstN) callReq |=> !callReq);

  p_ext_first_r6: assert property (@(posedge clk) disable iff (!rstN)
    callReq && $past(regRdData[4] && regRdData[1]) |-> callVector == 8'h04);

  p_men_cleared_r7: assert property (@(posedge clk) disable iff (!rstN) callReq |-> !regRdData[0]);

  p_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    callReq |-> $past(phaseTick) && $past(!stackFull) && $past(!regWrEn) && $past(regRdData[0]));

  p_reti_r9: assert property (@(posedge clk) disable iff (!rstN)
    retiStrobe && !regWrEn |=> regRdData[0] || callReq);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_checker #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .phaseTick(phaseTick), .regWrEn(regWrEn),
  .regRdData(regRdData), .stackFull(stackFull), .retiStrobe(retiStrobe),
  .callReq(callReq), .callVector(callVector)
);

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic phaseTick = 0, regWrEn = 0, extPinN = 1, timerOvf = 0, adcDone = 0;
  logic stackFull = 0, retiStrobe = 0, retStrobe = 0;
  logic [7:0] regWrData = 0;
  logic [7:0] regRdData;
  logic callReq;
  logic [7:0] callVector;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rstN(rstN), .phaseTick(phaseTick), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .extPinN(extPinN),
    .timerOvf(timerOvf), .adcDone(adcDone), .stackFull(stackFull),
    .retiStrobe(retiStrobe), .retStrobe(retStrobe),
    .callReq(callReq), .callVector(callVector)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d);
    regWrEn = 1; regWrData = d; step(); regWrEn = 0;
  endtask

  task automatic tick();
    phaseTick = 1; step(); phaseTick = 0;
  endtask

  task automatic expectCall(string tag, logic [7:0] vec, logic [7:0] regExp);
    chk({tag, " callReq"}, callReq, 1);
    chk({tag, " vector"}, callVector, vec);
    chk({tag, " reg"}, regRdData, regExp);
    step();
    chk({tag, " callReq single"}, callReq, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset reg", regRdData, 8'h00);
    chk("R1 reset callReq", callReq, 0);
  endtask

  task automatic t_write();
    wr(8'hFF); chk("R2 R1 write bit7 forced 0", regRdData, 8'h7F);
    wr(8'h00); chk("R2 write zero", regRdData, 8'h00);
  endtask

  task automatic t_ext_edge();
    extPinN = 0; step(); chk("R3 fall sets flag", regRdData, 8'h10);
    wr(8'h00); step(); step(); chk("R3 R11 low level no set", regRdData, 8'h00);
    extPinN = 1; step(); step(); chk("R3 rise no set", regRdData, 8'h00);
  endtask

  task automatic t_events();
    timerOvf = 1; step(); timerOvf = 0; chk("R4 timer flag", regRdData, 8'h20);
    adcDone = 1; step(); adcDone = 0; chk("R4 adc flag", regRdData, 8'h60);
    wr(8'h6E); tick(); chk("R12 men 0 no call", callReq, 0);
    chk("R12 flags kept", regRdData, 8'h6E);
    wr(8'h00);
  endtask

  task automatic t_priority();
    wr(8'h7F); tick(); expectCall("R5 R6 R7 ext", 8'h04, 8'h6E);
    retiStrobe = 1; step(); retiStrobe = 0; chk("R9 reti sets men", regRdData, 8'h6F);
    tick(); expectCall("R6 R7 timer", 8'h08, 8'h4E);
    retiStrobe = 1; step(); retiStrobe = 0;
    tick(); expectCall("R6 R7 adc", 8'h0C, 8'h0E);
  endtask

  task automatic t_stack();
    wr(8'h25); stackFull = 1; tick();
    chk("R8 held callReq", callReq, 0);
    chk("R8 flag kept", regRdData, 8'h25);
    stackFull = 0; tick(); expectCall("R8 served later", 8'h08, 8'h04);
  endtask

  task automatic t_between();
    wr(8'h0B); adcDone = 1; step(); adcDone = 0;
    chk("R10 flag set", regRdData, 8'h4B);
    for (int i = 0; i < 3; i++) begin step(); chk("R10 no call between ticks", callReq, 0); end
    tick(); expectCall("R10 served at tick", 8'h0C, 8'h0A);
  endtask

  task automatic t_ret();
    retStrobe = 1; step(); retStrobe = 0; chk("R9 ret leaves men", regRdData, 8'h0A);
    retiStrobe = 1; step(); retiStrobe = 0; chk("R9 reti", regRdData, 8'h0B);
  endtask

  task automatic t_disabled();
    wr(8'h03); timerOvf = 1; step(); timerOvf = 0;
    chk("R4 flag with source disabled", regRdData, 8'h23);
    tick(); chk("R12 disabled no call", callReq, 0);
    chk("R12 reg kept", regRdData, 8'h23);
  endtask

  task automatic t_wrprio();
    timerOvf = 1; wr(8'h01); timerOvf = 0; chk("R11 write beats set", regRdData, 8'h01);
    wr(8'h05); timerOvf = 1; step(); timerOvf = 0;
    regWrEn = 1; regWrData = 8'h25; phaseTick = 1; step();
    regWrEn = 0; phaseTick = 0;
    chk("R11 no grant in write cycle", callReq, 0);
    chk("R11 reg after write", regRdData, 8'h25);
    wr(8'h00);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rstN = 1;
    step();
    t_reset();
    t_write();
    t_ext_edge();
    t_events();
    t_priority();
    t_stack();
    t_between();
    t_ret();
    t_disabled();
    t_wrprio();
    step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule